// File: doc/BRIEF.md
# DMA Channel Control and Mask Unit

This block holds the control-port state of a four-channel DMA controller: a status byte with per-channel request and terminal-count flags, a four-bit mask, a command byte and one mode byte per channel. A host writes and reads it through eight byte-wide control offsets. A transfer engine drives it with hardware request hold and release lines and with per-channel completion pulses.

From the registered mask and request flags the block works out which channels may be serviced. It also names the lowest-numbered eligible channel. Each command that changes a mask or a request is therefore reflected in the eligibility outputs one clock later. A master clear, issued by a control write or by the reset input, returns the block to a known idle state.

Top module: `dma_ctrl_unit`

## Requirements
- R1: While `rstN` is low and after it rises: the command byte is 0x00, the status byte is 0x00, all mode bytes are 0x00 and all four mask bits are 1.
- R2: Status layout: bit n+4 is channel n's request flag and bit n is its terminal-count flag. While `rdEn` is high with `regOff`=0, `rdData` shows the status byte in the same cycle. Every other read and every idle cycle gives 0x00.
- R3: A status read (`rdEn`, `regOff`=0) clears all four terminal-count flags at the clock edge that ends the read. Request flags are kept.
- R4: A write to offset 1 sets channel `wrData[1:0]`'s request flag to `wrData[2]` and clears that channel's terminal-count flag.
- R5: A write to offset 2 sets channel `wrData[1:0]`'s mask bit to `wrData[2]`. The other mask bits are unchanged.
- R6: A write to offset 6 clears all mask bits. A write to offset 7 loads mask bit n from `wrData[n]`.
- R7: A `holdReq[n]` pulse sets channel n's request flag and a `releaseReq[n]` pulse clears it. Release wins over hold. Both win over a same-cycle offset-1 write to that channel.
- R8: A `tcDone[n]` pulse sets channel n's terminal-count flag. It wins over the clear done by a same-cycle status read or offset-1 write.
- R9: `eligible[n]` is 1 exactly when channel n's request flag is 1 and its mask bit is 0, as held in the registers. `svcValid` is high when any channel is eligible, and `svcChan` then gives the lowest eligible index.
- R10: A write to offset 0 loads `cmdOut`. A write to offset 3 loads mode byte `wrData[1:0]`, which appears on `chanMode[8n+7:8n]`. A write to offset 4 or 5 raises `ptrClr` during that write cycle.
- R11: A write to offset 5 sets all mask bits and clears the status and command bytes. It overrides every other input in that cycle and leaves the mode bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Control write strobe |
| rdEn | input | 1 | Control read strobe |
| regOff | input | 3 | Control offset |
| wrData | input | 8 | Write data |
| holdReq | input | 4 | Hardware request set, one per channel |
| releaseReq | input | 4 | Hardware request clear, one per channel |
| tcDone | input | 4 | Terminal-count pulse from the transfer engine |
| rdData | output | 8 | Read data |
| eligible | output | 4 | Channels with request set and mask clear |
| svcValid | output | 1 | At least one channel eligible |
| svcChan | output | 2 | Lowest eligible channel |
| cmdOut | output | 8 | Command byte |
| chanMode | output | 32 | Mode bytes, channel n in bits 8n+7:8n |
| ptrClr | output | 1 | Byte-pointer clear strobe |

## Verification
Two pairs of events can meet on the same flag in the same cycle. The first is a completion pulse and a status read that clears terminal counts. The second is a software request write and a hardware hold or release on the same channel. Directed steps force both collisions, and sparse random pulses let them recur during random traffic. The outcome is judged by later status reads and eligibility outputs, which must match a bench model that applies the priorities of R7, R8 and R11.

// File: rtl/dma_ctrl_pkg.sv
package dma_ctrl_pkg;
  localparam logic [2:0] OFF_CMD_STAT = 3'd0;
  localparam logic [2:0] OFF_REQ      = 3'd1;
  localparam logic [2:0] OFF_MASK1    = 3'd2;
  localparam logic [2:0] OFF_MODE     = 3'd3;
  localparam logic [2:0] OFF_PTR      = 3'd4;
  localparam logic [2:0] OFF_MCLR     = 3'd5;
  localparam logic [2:0] OFF_MASKCLR  = 3'd6;
  localparam logic [2:0] OFF_MASKALL  = 3'd7;

  typedef struct packed {
    logic cmdWr;
    logic reqWr;
    logic maskOneWr;
    logic modeWr;
    logic ptrClr;
    logic masterClr;
    logic maskClrAll;
    logic maskLoadAll;
    logic statRd;
  } ctrlStrobe_t;
endpackage

// File: rtl/dma_ctrl_decode.sv
module dma_ctrl_decode
  import dma_ctrl_pkg::*;
(
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  regOff,
  output ctrlStrobe_t stb
);
  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (regOff)
        OFF_CMD_STAT: stb.cmdWr       = 1'b1;
        OFF_REQ:      stb.reqWr       = 1'b1;
        OFF_MASK1:    stb.maskOneWr   = 1'b1;
        OFF_MODE:     stb.modeWr      = 1'b1;
        OFF_PTR:      stb.ptrClr      = 1'b1;
        OFF_MCLR:     stb.masterClr   = 1'b1;
        OFF_MASKCLR:  stb.maskClrAll  = 1'b1;
        default:      stb.maskLoadAll = 1'b1;
      endcase
    end
    if (rdEn && regOff == OFF_CMD_STAT) stb.statRd = 1'b1;
  end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_ctrl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              stb,
  input  logic [BYTE_W-1:0]        wrData,
  input  logic [NUM_CH-1:0]        holdReq,
  input  logic [NUM_CH-1:0]        releaseReq,
  input  logic [NUM_CH-1:0]        tcDone,
  output logic [NUM_CH-1:0]        reqQ,
  output logic [NUM_CH-1:0]        tcQ,
  output logic [NUM_CH-1:0]        maskQ,
  output logic [BYTE_W-1:0]        cmdQ,
  output logic [NUM_CH*BYTE_W-1:0] modeQ
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SET_BIT = CH_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cmdQ <= '0;
    else if (stb.masterClr) cmdQ <= '0;
    else if (stb.cmdWr)     cmdQ <= wrData;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [CH_W-1:0] IDX = CH_W'(i);
    logic chSel;
    assign chSel = (wrData[CH_W-1:0] == IDX);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqQ[i] <= 1'b0;
      end else if (stb.masterClr) begin
        reqQ[i] <= 1'b0;
      end else begin
        if (stb.reqWr && chSel) reqQ[i] <= wrData[SET_BIT];
        if (holdReq[i])         reqQ[i] <= 1'b1;
        if (releaseReq[i])      reqQ[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tcQ[i] <= 1'b0;
      end else if (stb.masterClr) begin
        tcQ[i] <= 1'b0;
      end else begin
        if (stb.statRd)         tcQ[i] <= 1'b0;
        if (stb.reqWr && chSel) tcQ[i] <= 1'b0;
        if (tcDone[i])          tcQ[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     maskQ[i] <= 1'b1;
      else if (stb.masterClr)        maskQ[i] <= 1'b1;
      else if (stb.maskClrAll)       maskQ[i] <= 1'b0;
      else if (stb.maskLoadAll)      maskQ[i] <= wrData[i];
      else if (stb.maskOneWr && chSel) maskQ[i] <= wrData[SET_BIT];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    modeQ[i*BYTE_W +: BYTE_W] <= '0;
      else if (stb.modeWr && chSel) modeQ[i*BYTE_W +: BYTE_W] <= wrData;
    end
  end
endmodule

// File: rtl/dma_ctrl_pick.sv
module dma_ctrl_pick #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] reqQ,
  input  logic [NUM_CH-1:0] maskQ,
  output logic [NUM_CH-1:0] eligible,
  output logic              svcValid,
  output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] svcChan
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  assign eligible = reqQ & ~maskQ;

  always_comb begin
    svcValid = 1'b0;
    svcChan  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        svcValid = 1'b1;
        svcChan  = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/dma_ctrl_unit.sv
module dma_ctrl_unit
  import dma_ctrl_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int BYTE_W = 2 * NUM_CH,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [2:0]               regOff,
  input  logic [BYTE_W-1:0]        wrData,
  input  logic [NUM_CH-1:0]        holdReq,
  input  logic [NUM_CH-1:0]        releaseReq,
  input  logic [NUM_CH-1:0]        tcDone,
  output logic [BYTE_W-1:0]        rdData,
  output logic [NUM_CH-1:0]        eligible,
  output logic                     svcValid,
  output logic [CH_W-1:0]          svcChan,
  output logic [BYTE_W-1:0]        cmdOut,
  output logic [NUM_CH*BYTE_W-1:0] chanMode,
  output logic                     ptrClr
);
  ctrlStrobe_t       stb;
  logic [NUM_CH-1:0] reqQ;
  logic [NUM_CH-1:0] tcQ;
  logic [NUM_CH-1:0] maskQ;
  logic [BYTE_W-1:0] statusQ;

  dma_ctrl_decode u_dec (
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .regOff(regOff),
    .stb   (stb)
  );

  dma_ctrl_regs #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .holdReq   (holdReq),
    .releaseReq(releaseReq),
    .tcDone    (tcDone),
    .reqQ      (reqQ),
    .tcQ       (tcQ),
    .maskQ     (maskQ),
    .cmdQ      (cmdOut),
    .modeQ     (chanMode)
  );

  dma_ctrl_pick #(.NUM_CH(NUM_CH)) u_pick (
    .reqQ    (reqQ),
    .maskQ   (maskQ),
    .eligible(eligible),
    .svcValid(svcValid),
    .svcChan (svcChan)
  );

  assign statusQ = {reqQ, tcQ};
  assign rdData  = stb.statRd ? statusQ : '0;
  assign ptrClr  = stb.ptrClr | stb.masterClr;
endmodule

// File: rtl/dma_ctrl_checker.sv
module dma_ctrl_checker #(
  parameter int NUM_CH = 4,
  localparam int BYTE_W = 2 * NUM_CH,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [2:0]        regOff,
  input logic [NUM_CH-1:0] holdReq,
  input logic [NUM_CH-1:0] releaseReq,
  input logic [NUM_CH-1:0] tcDone,
  input logic [BYTE_W-1:0] statusQ,
  input logic [NUM_CH-1:0] maskQ,
  input logic [BYTE_W-1:0] cmdOut,
  input logic [NUM_CH-1:0] eligible,
  input logic              svcValid,
  input logic [CH_W-1:0]   svcChan
);
  logic mclr;
  assign mclr = wrEn && regOff == 3'd5;

  AST_MASTER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    mclr |=> (maskQ == '1 && statusQ == '0 && cmdOut == '0)); // R11

  AST_DONE_SETS_TC: assert property (@(posedge clk) disable iff (!rstN)
    (tcDone != '0 && !mclr) |=> ((statusQ[NUM_CH-1:0] & $past(tcDone)) == $past(tcDone))); // R8

  AST_HOLD_SETS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ((holdReq & ~releaseReq) != '0 && !mclr)
      |=> ((statusQ[BYTE_W-1:NUM_CH] & $past(holdReq & ~releaseReq)) == $past(holdReq & ~releaseReq))); // R7

  AST_READ_CLEARS_TC: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regOff == 3'd0 && tcDone == '0) |=> (statusQ[NUM_CH-1:0] == '0)); // R3

  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regOff == 3'd6) |=> (maskQ == '0)); // R6

  AST_LOWEST_PICK: assert property (@(posedge clk) disable iff (!rstN)
    svcValid |-> (eligible[svcChan] && (eligible & ((NUM_CH'(1) << svcChan) - NUM_CH'(1))) == '0)); // R9

  AST_ELIG_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (eligible & maskQ) == '0); // R9
endmodule

bind dma_ctrl_unit dma_ctrl_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .regOff    (regOff),
  .holdReq   (holdReq),
  .releaseReq(releaseReq),
  .tcDone    (tcDone),
  .statusQ   (statusQ),
  .maskQ     (maskQ),
  .cmdOut    (cmdOut),
  .eligible  (eligible),
  .svcValid  (svcValid),
  .svcChan   (svcChan)
);

// File: tb/sim_dma_ctrl_unit.sv
`timescale 1ns/1ps
module sim_dma_ctrl_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0]  regOff = '0;
  logic [7:0]  wrData = '0;
  logic [3:0]  holdReq = '0, releaseReq = '0, tcDone = '0;
  logic [7:0]  rdData;
  logic [3:0]  eligible;
  logic        svcValid;
  logic [1:0]  svcChan;
  logic [7:0]  cmdOut;
  logic [31:0] chanMode;
  logic        ptrClr;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  logic [3:0]  mReq, mTc, mMask;
  logic [7:0]  mCmd;
  logic [31:0] mMode;

  always #4 clk = ~clk;

  dma_ctrl_unit u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regOff(regOff),
    .wrData(wrData), .holdReq(holdReq), .releaseReq(releaseReq), .tcDone(tcDone),
    .rdData(rdData), .eligible(eligible), .svcValid(svcValid), .svcChan(svcChan),
    .cmdOut(cmdOut), .chanMode(chanMode), .ptrClr(ptrClr)
  );

  function automatic logic [7:0] expStatus();
    return {mReq, mTc};
  endfunction

  function automatic logic [2:0] expPick(input logic [3:0] e);
    for (int i = 0; i < 4; i++) if (e[i]) return {1'b1, 2'(i)};
    return 3'b000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [2:0] o, input logic [7:0] d,
                      input logic [3:0] h, input logic [3:0] rl, input logic [3:0] dn,
                      input string tag);
    logic [3:0] e;
    logic [2:0] p;
    int ch;
    wrEn = w; rdEn = r; regOff = o; wrData = d;
    holdReq = h; releaseReq = rl; tcDone = dn;
    #1;
    e = mReq & ~mMask;
    p = expPick(e);
    chk({tag, " R2 rdData"}, rdData, (r && o == 3'd0) ? expStatus() : 8'h00);
    chk({tag, " R10 ptrClr"}, ptrClr, w && (o == 3'd4 || o == 3'd5));
    chk({tag, " R9 eligible"}, eligible, e);
    chk({tag, " R9 svcValid"}, svcValid, p[2]);
    if (p[2]) chk({tag, " R9 svcChan"}, svcChan, p[1:0]);
    chk({tag, " R10 cmdOut"}, cmdOut, mCmd);
    chk({tag, " R10 chanMode"}, chanMode, mMode);
    ch = int'(d[1:0]);
    if (w && o == 3'd5) begin
      mReq = '0; mTc = '0; mMask = '1; mCmd = '0;
    end else begin
      if (w) begin
        case (o)
          3'd0: mCmd = d;
          3'd1: begin mReq[ch] = d[2]; mTc[ch] = 1'b0; end
          3'd2: mMask[ch] = d[2];
          3'd3: mMode[ch*8 +: 8] = d;
          3'd6: mMask = '0;
          3'd7: mMask = d[3:0];
          default: ;
        endcase
      end
      if (r && o == 3'd0) mTc = '0;
      mReq = (mReq | h) & ~rl;
      mTc  = mTc | dn;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleRead(input string tag);
    step(1'b0, 1'b1, 3'd0, 8'h00, 4'h0, 4'h0, 4'h0, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    mReq = '0; mTc = '0; mMask = '1; mCmd = '0; mMode = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    #1;
    chk("R1 cmd in reset", cmdOut, 8'h00);
    chk("R1 mode in reset", chanMode, 32'h0);
    chk("R1 eligible in reset", eligible, 4'h0);
    rstN = 1'b1;
    @(negedge clk);
    idleRead("R1 status after reset");
    // R1: masks set, so held requests are not eligible
    step(1'b0, 1'b0, 3'd0, 8'h00, 4'hF, 4'h0, 4'h0, "R1 hold all");
    chk("R1 masks all set", eligible, 4'h0);
    // R6 clear all masks, then load pattern
    step(1'b1, 1'b0, 3'd6, 8'h00, 4'h0, 4'h0, 4'h0, "R6 clear masks");
    step(1'b1, 1'b0, 3'd7, 8'h05, 4'h0, 4'h0, 4'h0, "R6 load masks");
    // R5 single mask on channel 1 and off channel 2
    step(1'b1, 1'b0, 3'd2, 8'h05, 4'h0, 4'h0, 4'h0, "R5 mask ch1");
    step(1'b1, 1'b0, 3'd2, 8'h02, 4'h0, 4'h0, 4'h0, "R5 unmask ch2");
    // R4 request write and tc clear
    step(1'b0, 1'b0, 3'd0, 8'h00, 4'h0, 4'h0, 4'h6, "R8 done ch1 ch2");
    step(1'b1, 1'b0, 3'd1, 8'h01, 4'h0, 4'h0, 4'h0, "R4 clear req ch1");
    idleRead("R4 status after req write");
    // R8 collision: done pulse with status read
    step(1'b0, 1'b0, 3'd0, 8'h00, 4'h0, 4'h0, 4'h1, "R8 done ch0");
    step(1'b0, 1'b1, 3'd0, 8'h00, 4'h0, 4'h0, 4'h8, "R8 read vs done");
    idleRead("R3 tc kept for ch3 only");
    idleRead("R3 tc cleared");
    // R8 collision: done with request write same channel
    step(1'b1, 1'b0, 3'd1, 8'h02, 4'h0, 4'h0, 4'h4, "R8 reqwr vs done");
    idleRead("R8 check");
    // R7 collisions: software set vs release, software clear vs hold, hold vs release
    step(1'b1, 1'b0, 3'd1, 8'h07, 4'h0, 4'h8, 4'h0, "R7 set vs release");
    step(1'b1, 1'b0, 3'd1, 8'h02, 4'h4, 4'h0, 4'h0, "R7 clear vs hold");
    step(1'b0, 1'b0, 3'd0, 8'h00, 4'h2, 4'h2, 4'h0, "R7 hold vs release");
    idleRead("R7 check");
    // R10 command, mode, pointer strobe
    step(1'b1, 1'b0, 3'd0, 8'hA5, 4'h0, 4'h0, 4'h0, "R10 cmd");
    step(1'b1, 1'b0, 3'd3, 8'h5B, 4'h0, 4'h0, 4'h0, "R10 mode ch3");
    step(1'b1, 1'b0, 3'd4, 8'h00, 4'h0, 4'h0, 4'h0, "R10 ptr");
    // R11 master clear against hold and done
    step(1'b1, 1'b0, 3'd5, 8'hFF, 4'hF, 4'h0, 4'hF, "R11 master clear");
    idleRead("R11 status after clear");
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int op;
      logic [2:0] o;
      op = $urandom_range(0, 3);
      o = 3'($urandom_range(0, 7));
      if (o == 3'd5 && $urandom_range(0, 7) != 0) o = 3'd1;
      if (op == 2 && $urandom_range(0, 1) == 0) o = 3'd0;
      step(op == 1 || op == 3, op == 2, o, 8'($urandom),
           4'($urandom & $urandom & $urandom), 4'($urandom & $urandom & $urandom),
           4'($urandom & $urandom), "random");
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule